// File: doc/BRIEF.md
# Mode-Selectable Barrel Shifter

This block moves an N-bit word by any distance from 0 to N-1 positions within the same cycle. The move can go left or right. It can be a logical shift, which brings in zeros, or a rotation, which puts the bits that leave one end back in at the other end. A 2-bit mode code selects both the type and the direction. All four operations share one multiplexer datapath, so a datapath can use the block as a general-purpose alignment or rotate unit.

The logic is purely combinational. The width N is a power-of-two parameter, 4 by default, and the distance input is log2(N) bits wide. The core is a cascade of log2(N) layers of 2:1 multiplexers. Layer k moves the word by 2^k positions when distance bit k is set, which costs about N·log2(N) multiplexers in total. The core only moves data left. A right move mirrors the word bit by bit on entry and mirrors it back on exit.

Top module: `bshift_top`

## Requirements
- R1: The mode field works as follows. Bit 1 selects the type: 1 means rotate, 0 means logical. Bit 0 selects the direction: 1 means left, 0 means right. The four codes are therefore 00 logical right, 01 logical left, 10 rotate right and 11 rotate left.
- R2: A logical left shift by d places data_in[i] at data_out[i+d] and drives the lowest d output bits to 0. For example, 1101 shifted left by 2 gives 0100.
- R3: A logical right shift by d places data_in[i] at data_out[i-d] and drives the highest d output bits to 0. For example, 1101 shifted right by 1 gives 0110.
- R4: A rotate left by d places data_in[i] at data_out[(i+d) mod N]. A rotate left by 1 therefore moves bit N-1 into bit 0.
- R5: A rotate right by d places data_in[i] at data_out[(i-d) mod N]. For example, 1101 rotated right by 1 gives 1110.
- R6: A distance of 0 returns data_in unchanged in all four modes.
- R7: N is a power of two and at least 2, and the distance width is log2(N). The rules R2 to R5 hold at every such width, including 8 and 16.
- R8: A rotation keeps the number of ones in the word. For N=4, a rotate left by d equals a rotate right by N-d.
- R9: data_out depends only on the present inputs and holds no state. Every combination of data, mode and distance drives every output bit to a known value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | N | Word to be moved |
| mode_in | input | 2 | Bit 1: rotate (1) or logical (0); bit 0: left (1) or right (0) |
| dist_in | input | log2(N) | Distance to move, 0 to N-1 positions |
| data_out | output | N | Moved word |

## Verification
The block holds no registers, so every result is due in the same cycle as its stimulus, with zero clock edges of delay. The bench drives new inputs just after a rising edge and reads data_out at the following falling edge, half a period later. By then the combinational paths have settled and no new stimulus has been applied. Expected words come from a shift-and-concatenate model inside the bench. The bench applies every input combination at width 4 and random vectors at widths 8 and 16.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    // Mode code: the upper bit picks the kind of move, the lower bit the direction.
    typedef struct packed {
        logic rotate;   // 1: bits wrap around, 0: vacated bits become zero
        logic left;     // 1: toward the MSB, 0: toward the LSB
    } bs_mode_t;

    localparam bs_mode_t MODE_LSR = '{rotate: 1'b0, left: 1'b0};
    localparam bs_mode_t MODE_LSL = '{rotate: 1'b0, left: 1'b1};
    localparam bs_mode_t MODE_ROR = '{rotate: 1'b1, left: 1'b0};
    localparam bs_mode_t MODE_ROL = '{rotate: 1'b1, left: 1'b1};

endpackage

// File: rtl/bshift_mirror.sv
// Conditional bit-order reversal: a right move is done as mirror, move left, mirror.
module bshift_mirror #(
    parameter int N = 4
) (
    input  logic [N-1:0] din,
    input  logic         flip,
    output logic [N-1:0] dout
);

    logic [N-1:0] rev_d;

    for (genvar i = 0; i < N; i++) begin : g_rev
        assign rev_d[i] = din[N-1-i];
    end

    always_comb begin
        dout = flip ? rev_d : din;
    end

endmodule

// File: rtl/bshift_layer.sv
// One multiplexer layer: moves the word left by AMT positions when sel is set.
// Positions freed at the bottom are refilled from the top (wrap) or with zero.
module bshift_layer #(
    parameter int N   = 4,
    parameter int AMT = 1
) (
    input  logic [N-1:0] din,
    input  logic         sel,
    input  logic         wrap,
    output logic [N-1:0] dout
);

    logic [N-1:0] moved_d;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i >= AMT) begin : g_inner
            assign moved_d[i] = din[i-AMT];
        end else begin : g_edge
            assign moved_d[i] = wrap & din[N-AMT+i];
        end
    end

    always_comb begin
        dout = sel ? moved_d : din;
    end

endmodule

// File: rtl/bshift_top.sv
module bshift_top
    import bshift_pkg::*;
#(
    parameter  int N  = 4,
    localparam int DW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  data_in,
    input  logic [1:0]    mode_in,
    input  logic [DW-1:0] dist_in,
    output logic [N-1:0]  data_out
);

    bs_mode_t mode_d;
    logic [N-1:0] entry_d;
    logic [DW:0][N-1:0] lane_d;

    always_comb begin
        mode_d = bs_mode_t'(mode_in);
    end

    // Right moves enter the left-only core mirrored.
    bshift_mirror #(.N(N)) u_mirror_in (
        .din  (data_in),
        .flip (~mode_d.left),
        .dout (entry_d)
    );

    assign lane_d[0] = entry_d;

    // Layer k moves by 2^k when distance bit k is set.
    for (genvar k = 0; k < DW; k++) begin : g_layer
        bshift_layer #(.N(N), .AMT(1 << k)) u_layer (
            .din  (lane_d[k]),
            .sel  (dist_in[k]),
            .wrap (mode_d.rotate),
            .dout (lane_d[k+1])
        );
    end

    bshift_mirror #(.N(N)) u_mirror_out (
        .din  (lane_d[DW]),
        .flip (~mode_d.left),
        .dout (data_out)
    );

endmodule

// File: rtl/bshift_chk.sv
module bshift_chk #(
    parameter int N  = 4,
    parameter int DW = 2
) (
    input logic [N-1:0]  data_in,
    input logic [1:0]    mode_in,
    input logic [DW-1:0] dist_in,
    input logic [N-1:0]  data_out
);

    logic [N-1:0] low_mask;
    logic [N-1:0] high_mask;

    initial begin
        assert_width_pow2_R7: assert (N >= 2 && (N & (N - 1)) == 0 && (1 << DW) == N)
            else $error("width must be a power of two of at least 2");
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            low_mask[i]  = (i < int'(dist_in));
            high_mask[i] = (i >= N - int'(dist_in));
        end
    end

    always_comb begin
        assert_zero_dist_R6: assert (dist_in != '0 || data_out == data_in)
            else $error("distance 0 changed the word");
        assert_rot_ones_R8: assert (!mode_in[1] || $countones(data_out) == $countones(data_in))
            else $error("rotation changed the number of ones");
        assert_lsl_fill_R2: assert (mode_in != 2'b01 || (data_out & low_mask) == '0)
            else $error("logical left left nonzero low bits");
        assert_lsr_fill_R3: assert (mode_in != 2'b00 || (data_out & high_mask) == '0)
            else $error("logical right left nonzero high bits");
        assert_rol_wrap_R4: assert (!(mode_in == 2'b11 && dist_in == DW'(1)) || data_out[0] == data_in[N-1])
            else $error("rotate left by 1 lost the top bit");
        assert_ror_wrap_R5: assert (!(mode_in == 2'b10 && dist_in == DW'(1)) || data_out[N-1] == data_in[0])
            else $error("rotate right by 1 lost the bottom bit");
        assert_known_R9: assert (!$isunknown({data_in, mode_in, dist_in}) || !$isunknown(data_out))
            else $error("unknown output for known inputs");
    end

endmodule

bind bshift_top bshift_chk #(.N(N), .DW(DW)) u_chk (
    .data_in  (data_in),
    .mode_in  (mode_in),
    .dist_in  (dist_in),
    .data_out (data_out)
);

// File: tb/bshift_top_tb.sv
`timescale 1ns/1ps
module bshift_top_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]  a4 = '0;  logic [1:0] m4 = '0; logic [1:0] d4 = '0; logic [3:0]  y4;
    logic [7:0]  a8 = '0;  logic [1:0] m8 = '0; logic [2:0] d8 = '0; logic [7:0]  y8;
    logic [15:0] a16 = '0; logic [1:0] m16 = '0; logic [3:0] d16 = '0; logic [15:0] y16;

    bshift_top #(.N(4)) u_dut (.data_in(a4), .mode_in(m4), .dist_in(d4), .data_out(y4));
    bshift_top #(.N(8)) u_dut8 (.data_in(a8), .mode_in(m8), .dist_in(d8), .data_out(y8));
    bshift_top #(.N(16)) u_dut16 (.data_in(a16), .mode_in(m16), .dist_in(d16), .data_out(y16));

    // Directed table for N=4: {data, mode, distance, expected}
    localparam logic [11:0] VEC [10] = '{
        {4'b1101, 2'b10, 2'd1, 4'b1110},   // R5 rotate right
        {4'b1101, 2'b01, 2'd2, 4'b0100},   // R2 logical left
        {4'b1101, 2'b00, 2'd1, 4'b0110},   // R3 logical right
        {4'b1101, 2'b11, 2'd1, 4'b1011},   // R4 rotate left
        {4'b1101, 2'b11, 2'd3, 4'b1110},   // R8 rotl 3 == rotr 1
        {4'b1001, 2'b00, 2'd3, 4'b0001},   // R3 / R1 code 00
        {4'b1001, 2'b01, 2'd3, 4'b1000},   // R2 / R1 code 01
        {4'b0110, 2'b10, 2'd0, 4'b0110},   // R6
        {4'b0110, 2'b01, 2'd0, 4'b0110},   // R6
        {4'b1000, 2'b11, 2'd1, 4'b0001}    // R4 top bit wraps to bit 0
    };

    function automatic logic [15:0] model(input logic [15:0] x, input int w,
                                          input logic [1:0] m, input int d);
        logic [31:0] mask;
        logic [31:0] v;
        logic [31:0] r;
        mask = (32'd1 << w) - 32'd1;
        v = {16'd0, x} & mask;
        case (m)
            2'b00:   r = v >> d;
            2'b01:   r = v << d;
            2'b10:   r = (v >> d) | (v << (w - d));
            default: r = (v << d) | (v >> (w - d));
        endcase
        return 16'(r & mask);
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive4(input logic [3:0] a, input logic [1:0] m, input logic [1:0] d);
        @(posedge clk); #1;
        a4 = a; m4 = m; d4 = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: zero inputs after reset give zero output on all widths
        check("R9 reset n4", {12'd0, y4}, 16'd0);
        check("R9 reset n8", {8'd0, y8}, 16'd0);
        check("R9 reset n16", y16, 16'd0);

        foreach (VEC[i]) begin
            drive4(VEC[i][11:8], VEC[i][7:6], VEC[i][5:4]);
            check("R1/R2/R3/R4/R5/R6/R8 table", {12'd0, y4}, {12'd0, VEC[i][3:0]});
        end

        // R9 / R1: exhaustive at N=4
        for (int a = 0; a < 16; a++) begin
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 4; d++) begin
                    drive4(4'(a), 2'(m), 2'(d));
                    check("R9 exhaustive n4", {12'd0, y4}, model(16'(a), 4, 2'(m), d));
                end
            end
        end

        // R8: rotate left by d equals rotate right by 4-d
        for (int d = 1; d < 4; d++) begin
            logic [3:0] lft;
            drive4(4'b1011, 2'b11, 2'(d));
            lft = y4;
            drive4(4'b1011, 2'b10, 2'(4 - d));
            check("R8 rol/ror equivalence", {12'd0, y4}, {12'd0, lft});
        end

        // R7: random vectors at N=8 and N=16
        for (int n = 0; n < 400; n++) begin
            @(posedge clk); #1;
            a8 = 8'($urandom);   m8 = 2'($urandom);  d8 = 3'($urandom);
            a16 = 16'($urandom); m16 = 2'($urandom); d16 = 4'($urandom);
            @(negedge clk);
            check("R7 random n8", {8'd0, y8}, model({8'd0, a8}, 8, m8, int'(d8)));
            check("R7 random n16", y16, model(a16, 16, m16, int'(d16)));
        end

        // R2 / R3 / R4 / R5 at the widest distance for N=16
        for (int m = 0; m < 4; m++) begin
            @(posedge clk); #1;
            a16 = 16'h8001; m16 = 2'(m); d16 = 4'd15;
            @(negedge clk);
            check("R2/R3/R4/R5 max distance n16", y16, model(16'h8001, 16, 2'(m), 15));
        end

        // R6 at N=8 and N=16 in every mode
        for (int m = 0; m < 4; m++) begin
            @(posedge clk); #1;
            a8 = 8'hA7; m8 = 2'(m); d8 = '0;
            a16 = 16'h5A3C; m16 = 2'(m); d16 = '0;
            @(negedge clk);
            check("R6 zero distance n8", {8'd0, y8}, 16'h00A7);
            check("R6 zero distance n16", y16, 16'h5A3C);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule